// File: doc/BRIEF.md
# Serial Bus Reset Sequencer

This block decides when a cable physical-layer node drives a bus reset, which kind of reset it drives, and how long a reset seen on the bus lasts. A static mode input picks one of two behaviours. With the input high the node runs in legacy mode: every reset it starts or receives is long. With the input low the node may first win arbitration and then drive a much shorter reset. In that mode it still drives long resets when asked and still handles long resets from other nodes.

Software starts a reset by writing to a small request register. The block holds the bus through a request/grant handshake with an external arbiter. It counts every duration in cycles of the reference clock, and the counts are parameters. The defaults assume a 24.576 MHz clock: about 200 µs for a long reset, about 1.34 µs for a short reset, and a total arbitration-plus-short-reset window of 80 µs. Each reset, whether local or received, ends with a one-cycle completion pulse.

Top module: `bus_reset_seq`

## Requirements
- R1: With `legacy_mode` high, writing 1 to bit 7 of register 9 starts a long reset driven on `bus_reset_tx`, and `arb_req` never rises.
- R2: With `legacy_mode` high, a rising edge on `rx_reset` with `rx_short` high is timed as a long reset, with `reset_short` low.
- R3: With `legacy_mode` low, writing 1 to bit 7 of register 9 raises `arb_req`. On the cycle after `arb_gnt` is sampled high, `arb_req` drops and `bus_reset_tx` plus `reset_short` stay high for SHORT_CYCLES cycles.
- R4: A long reset keeps `reset_active` high for LONG_CYCLES cycles.
- R5: With `legacy_mode` low, a received reset is short (SHORT_CYCLES, `reset_short` high) when `rx_short` is high at the rising edge of `rx_reset`, and long otherwise. `bus_reset_tx` stays low for received resets.
- R6: With `legacy_mode` low, writing 1 to bit 6 of register 9 starts a long reset without raising `arb_req`.
- R7: If no grant arrives within ARB_WINDOW_CYCLES − SHORT_CYCLES cycles of `arb_req`, the block drops `arb_req` and drives a long reset instead.
- R8: A read of register 9 returns a pending bit 7 or bit 6 request as 1. That bit reads 0 once the block has taken the request, one cycle after the write.
- R9: A register write that arrives while a reset or arbitration is in progress is discarded and starts no later reset.
- R10: `reset_done` is high for exactly one cycle: the first cycle after `reset_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | 1 = long resets only; 0 = arbitrated short resets allowed |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | DATA_W | Write data; bit 7 = short request, bit 6 = long request |
| reg_rd_data | output | DATA_W | Read data for `reg_addr` |
| arb_req | output | 1 | Bus arbitration request |
| arb_gnt | input | 1 | Bus arbitration grant |
| rx_reset | input | 1 | Reset detected on the bus; a rising edge starts timing |
| rx_short | input | 1 | Received reset announced as arbitrated/short |
| bus_reset_tx | output | 1 | This node is driving a reset on the bus |
| reset_active | output | 1 | A reset (local or received) is in progress |
| reset_short | output | 1 | The current reset is the short kind |
| reset_done | output | 1 | One-cycle pulse when a reset ends |

## Verification
The bench aims at the downgrade paths. A bit 7 write in legacy mode must give a long reset with no arbitration, and a received short reset in legacy mode must last LONG_CYCLES. A design that skipped either downgrade would show a reset of SHORT_CYCLES, or a stray `arb_req`. The bench withholds the grant until the arbitration window ends. A design without the fallback would hang in arbitration, and one with an off-by-one window would report the wrong number of request cycles. A write issued in the middle of a long reset must leave the request register at 0 and cause no second reset. A design that latched that write would produce an unexpected reset, which the scoreboard flags.

// File: rtl/bus_reset_pkg.sv
package bus_reset_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_TX_SHORT,
        ST_TX_LONG,
        ST_RX_SHORT,
        ST_RX_LONG
    } seq_state_e;

    // Request register location and bit positions seen by software.
    localparam int REQ_REG_ADDR  = 9;
    localparam int REQ_SHORT_BIT = 7;
    localparam int REQ_LONG_BIT  = 6;

endpackage

// File: rtl/rst_req_regs.sv
module rst_req_regs
    import bus_reset_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              consume,
    output logic [DATA_W-1:0] rd_data,
    output logic              short_req_o,
    output logic              long_req_o
);

    typedef struct packed {
        logic short_req;
        logic long_req;
    } req_t;

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REQ_REG_ADDR);

    req_t req_d, req_q;
    logic hit;

    always_comb begin
        hit   = wr_en && (addr == MY_ADDR);
        req_d = req_q;
        if (consume) begin
            req_d = '0;
        end else if (hit && !busy) begin
            if (wr_data[REQ_SHORT_BIT]) req_d.short_req = 1'b1;
            if (wr_data[REQ_LONG_BIT])  req_d.long_req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == MY_ADDR) begin
            rd_data[REQ_SHORT_BIT] = req_q.short_req;
            rd_data[REQ_LONG_BIT]  = req_q.long_req;
        end
    end

    assign short_req_o = req_q.short_req;
    assign long_req_o  = req_q.long_req;

    AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (!short_req_o && !long_req_o)); // R8

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !short_req_o && !long_req_o) |=> (!short_req_o && !long_req_o)); // R9

endmodule

// File: rtl/rst_duration_timer.sv
module rst_duration_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import bus_reset_pkg::*;
#(
    parameter int LONG_CYCLES  = 4916,
    parameter int SHORT_CYCLES = 33,
    parameter int ARB_LIMIT    = 1933,
    parameter int CNT_W        = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             legacy_mode,
    input  logic             req_short,
    input  logic             req_long,
    input  logic             rx_reset,
    input  logic             rx_short,
    input  logic             arb_gnt,
    input  logic             tmr_zero,
    output logic             consume,
    output logic             busy,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             arb_req,
    output logic             bus_reset_tx,
    output logic             reset_active,
    output logic             reset_short,
    output logic             reset_done
);

    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYCLES - 1);
    localparam logic [CNT_W-1:0] ARB_LD   = CNT_W'(ARB_LIMIT - 1);

    typedef struct packed {
        seq_state_e st;
        logic       rx_prev;
        logic       done;
    } fsm_t;

    fsm_t f_d, f_q;
    logic rx_rise;
    logic rx_as_short;

    always_comb begin
        f_d         = f_q;
        f_d.rx_prev = rx_reset;
        f_d.done    = 1'b0;
        rx_rise     = rx_reset && !f_q.rx_prev;
        rx_as_short = rx_short && !legacy_mode;
        consume     = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = LONG_LD;

        unique case (f_q.st)
            ST_IDLE: begin
                if (rx_rise) begin
                    consume  = 1'b1;
                    tmr_load = 1'b1;
                    if (rx_as_short) begin
                        f_d.st  = ST_RX_SHORT;
                        tmr_val = SHORT_LD;
                    end else begin
                        f_d.st  = ST_RX_LONG;
                    end
                end else if (req_short && !legacy_mode) begin
                    consume  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = ARB_LD;
                    f_d.st   = ST_ARB;
                end else if (req_short || req_long) begin
                    consume  = 1'b1;
                    tmr_load = 1'b1;
                    f_d.st   = ST_TX_LONG;
                end
            end
            ST_ARB: begin
                if (rx_rise) begin
                    tmr_load = 1'b1;
                    if (rx_as_short) begin
                        f_d.st  = ST_RX_SHORT;
                        tmr_val = SHORT_LD;
                    end else begin
                        f_d.st  = ST_RX_LONG;
                    end
                end else if (arb_gnt) begin
                    tmr_load = 1'b1;
                    tmr_val  = SHORT_LD;
                    f_d.st   = ST_TX_SHORT;
                end else if (tmr_zero) begin
                    tmr_load = 1'b1;
                    f_d.st   = ST_TX_LONG;
                end
            end
            ST_TX_SHORT, ST_TX_LONG, ST_RX_SHORT, ST_RX_LONG: begin
                if (tmr_zero) begin
                    f_d.st   = ST_IDLE;
                    f_d.done = 1'b1;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st      <= ST_IDLE;
            f_q.rx_prev <= 1'b0;
            f_q.done    <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        busy         = (f_q.st != ST_IDLE);
        arb_req      = (f_q.st == ST_ARB);
        bus_reset_tx = (f_q.st == ST_TX_SHORT) || (f_q.st == ST_TX_LONG);
        reset_active = bus_reset_tx || (f_q.st == ST_RX_SHORT) || (f_q.st == ST_RX_LONG);
        reset_short  = (f_q.st == ST_TX_SHORT) || (f_q.st == ST_RX_SHORT);
        reset_done   = f_q.done;
    end

    AST_ARB_TIMEOUT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_ARB && tmr_zero && !arb_gnt && !rx_rise) |=> (f_q.st == ST_TX_LONG)); // R7

    AST_GRANT_TO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && arb_gnt && !rx_rise) |=> (bus_reset_tx && reset_short)); // R3

endmodule

// File: rtl/bus_reset_seq.sv
module bus_reset_seq #(
    parameter int LONG_CYCLES       = 4916,
    parameter int SHORT_CYCLES      = 33,
    parameter int ARB_WINDOW_CYCLES = 1966,
    parameter int ADDR_W            = 4,
    parameter int DATA_W            = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              arb_req,
    input  logic              arb_gnt,
    input  logic              rx_reset,
    input  logic              rx_short,
    output logic              bus_reset_tx,
    output logic              reset_active,
    output logic              reset_short,
    output logic              reset_done
);

    localparam int ARB_LIMIT = ARB_WINDOW_CYCLES - SHORT_CYCLES;
    localparam int MAX_CYC   = (LONG_CYCLES > ARB_LIMIT) ? LONG_CYCLES : ARB_LIMIT;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             req_short, req_long;
    logic             consume, busy;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    rst_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wr_en       (reg_wr_en),
        .wr_data     (reg_wr_data),
        .busy        (busy),
        .consume     (consume),
        .rd_data     (reg_rd_data),
        .short_req_o (req_short),
        .long_req_o  (req_long)
    );

    rst_duration_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero_o   (tmr_zero)
    );

    rst_seq_fsm #(
        .LONG_CYCLES  (LONG_CYCLES),
        .SHORT_CYCLES (SHORT_CYCLES),
        .ARB_LIMIT    (ARB_LIMIT),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .legacy_mode  (legacy_mode),
        .req_short    (req_short),
        .req_long     (req_long),
        .rx_reset     (rx_reset),
        .rx_short     (rx_short),
        .arb_gnt      (arb_gnt),
        .tmr_zero     (tmr_zero),
        .consume      (consume),
        .busy         (busy),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .arb_req      (arb_req),
        .bus_reset_tx (bus_reset_tx),
        .reset_active (reset_active),
        .reset_short  (reset_short),
        .reset_done   (reset_done)
    );

    // Checker-side counters for windows too long to unroll.
    logic [CNT_W:0] arb_run_q;
    logic [CNT_W:0] act_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_run_q <= '0;
            act_run_q <= '0;
        end else begin
            arb_run_q <= arb_req ? arb_run_q + 1'b1 : '0;
            act_run_q <= reset_active ? act_run_q + 1'b1 : '0;
        end
    end

    AST_LEGACY_NO_ARB: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |-> !arb_req); // R1

    AST_LEGACY_LONG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_mode && $rose(reset_active)) |-> !reset_short); // R2

    AST_NO_ARB_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_req && reset_active)); // R3

    AST_ACTIVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        act_run_q <= (CNT_W+1)'(LONG_CYCLES)); // R4

    AST_ARB_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        arb_run_q <= (CNT_W+1)'(ARB_LIMIT)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |=> !reset_done); // R10

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_active) |-> reset_done); // R10

endmodule

// File: tb/tb_bus_reset_seq.sv
module tb_bus_reset_seq;

    localparam int LONG_C  = 60;
    localparam int SHORT_C = 10;
    localparam int WIN_C   = 40;
    localparam int ARB_LIM = WIN_C - SHORT_C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       legacy_mode = 1'b0;
    logic [3:0] reg_addr = 4'd9;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       arb_req;
    logic       arb_gnt = 1'b0;
    logic       rx_reset = 1'b0;
    logic       rx_short = 1'b0;
    logic       bus_reset_tx, reset_active, reset_short, reset_done;

    always #5 clk = ~clk;

    bus_reset_seq #(
        .LONG_CYCLES(LONG_C), .SHORT_CYCLES(SHORT_C), .ARB_WINDOW_CYCLES(WIN_C)
    ) dut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .arb_req(arb_req), .arb_gnt(arb_gnt),
        .rx_reset(rx_reset), .rx_short(rx_short), .bus_reset_tx(bus_reset_tx),
        .reset_active(reset_active), .reset_short(reset_short), .reset_done(reset_done)
    );

    typedef struct {
        bit    tx;
        bit    shrt;
        int    len;
        int    arb;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   n_seen = 0;
    int   n_pushed = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic push(input bit tx, input bit shrt, input int len, input int arb,
                        input string req);
        exp_t e;
        e.tx = tx; e.shrt = shrt; e.len = len; e.arb = arb; e.req = req;
        sb_q.push_back(e);
        n_pushed++;
    endtask

    // Monitor: measures each reset and compares against the scoreboard.
    initial begin
        bit prev_active = 1'b0;
        bit prev_done   = 1'b0;
        bit st_tx = 1'b0, st_short = 1'b0;
        int len = 0, arb = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (arb_req) arb++;
                if (reset_active) begin
                    if (!prev_active) begin
                        st_tx    = bus_reset_tx;
                        st_short = reset_short;
                    end
                    len++;
                end
                if (reset_done) begin
                    exp_t e;
                    n_seen++;
                    check(!prev_done, "R10", "done width", 2, 1);
                    check(prev_active && !reset_active, "R10", "done after active",
                          int'(reset_active), 0);
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R9", "unexpected reset", n_seen, n_pushed);
                    end else begin
                        e = sb_q.pop_front();
                        check(st_tx == e.tx, e.req, "driven flag", int'(st_tx), int'(e.tx));
                        check(st_short == e.shrt, e.req, "short flag",
                              int'(st_short), int'(e.shrt));
                        check(len == e.len, e.req, "length", len, e.len);
                        if (e.arb >= 0)
                            check(arb == e.arb, e.req, "arb_req cycles", arb, e.arb);
                    end
                    len = 0;
                    arb = 0;
                end
                prev_active = reset_active;
                prev_done   = reset_done;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_up();
    end

    task automatic wait_drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic write_req(input logic [7:0] data, input logic [1:0] exp_pend,
                             input string req);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(reg_rd_data[7:6] == exp_pend, req, "pending read",
              int'(reg_rd_data[7:6]), int'(exp_pend));
        @(negedge clk);
        check(reg_rd_data[7:6] == 2'b00, req, "read after accept",
              int'(reg_rd_data[7:6]), 0);
    endtask

    task automatic grant_after(input int waits);
        while (!arb_req) @(negedge clk);
        repeat (waits - 1) @(negedge clk);
        arb_gnt = 1'b1;
        @(negedge clk);
        arb_gnt = 1'b0;
    endtask

    task automatic pulse_rx(input bit shrt);
        @(negedge clk);
        rx_reset = 1'b1;
        rx_short = shrt;
        @(negedge clk);
        rx_reset = 1'b0;
        rx_short = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(!arb_req, "R10", "arb_req at reset", int'(arb_req), 0);
        check(!reset_active && !bus_reset_tx, "R4", "active at reset",
              int'(reset_active), 0);
        check(reg_rd_data == 8'h00, "R8", "reg at reset", int'(reg_rd_data), 0);

        // R3: arbitrated short reset, grant on third request cycle
        legacy_mode = 1'b0;
        push(1, 1, SHORT_C, 3, "R3");
        fork
            write_req(8'h80, 2'b10, "R8");
            grant_after(3);
        join
        wait_drain();

        // R1: legacy, short request becomes long, no arbitration
        legacy_mode = 1'b1;
        push(1, 0, LONG_C, 0, "R1");
        write_req(8'h80, 2'b10, "R1");
        wait_drain();

        // R6: long request in short-reset mode
        legacy_mode = 1'b0;
        push(1, 0, LONG_C, 0, "R6");
        write_req(8'h40, 2'b01, "R6");
        wait_drain();

        // R5: received short reset in short mode
        push(0, 1, SHORT_C, 0, "R5");
        pulse_rx(1'b1);
        wait_drain();

        // R2: received short reset in legacy mode is long
        legacy_mode = 1'b1;
        push(0, 0, LONG_C, 0, "R2");
        pulse_rx(1'b1);
        wait_drain();

        // R5 / R4: received long reset in short mode
        legacy_mode = 1'b0;
        push(0, 0, LONG_C, 0, "R4");
        pulse_rx(1'b0);
        wait_drain();

        // R7: no grant, fallback to long
        push(1, 0, LONG_C, ARB_LIM, "R7");
        write_req(8'h80, 2'b10, "R7");
        wait_drain();

        // R9: write during a long reset is dropped
        push(1, 0, LONG_C, 0, "R9");
        write_req(8'h40, 2'b01, "R9");
        repeat (20) @(negedge clk);
        write_req(8'hC0, 2'b00, "R9");
        wait_drain();
        repeat (2 * LONG_C) @(negedge clk);
        check(n_seen == n_pushed, "R9", "resets observed", n_seen, n_pushed);
        check(!reset_active && !arb_req, "R9", "idle after drop",
              int'(reset_active | arb_req), 0);

        finish_up();
    end

endmodule